// File: doc/BRIEF.md
# Flash IAP mailbox controller

This block is the in-application programming controller between the byte-wide special-function-register bus of an 8-bit CPU and a flash array built as two blocks. Software loads a target address, a data byte and a configuration byte into a small mailbox. It then writes an operation code into the command register. The controller checks whether the request is allowed. It then works out which physical flash block the 16-bit target address refers to. The answer depends on the external-access input, the two bank-select bits and the place the requesting instruction was fetched from. If the request passes, the controller drives a program or block-erase enable towards the flash array for a counted number of cycles.

The lower region of the address map, below `LOW_SPAN` (2000H by default), is where block 1 can be overlaid on block 0. Code may never change the block it is running from: any request that resolves to that block is dropped and flagged. The timing oscillator enable is high only while an operation runs.

Top module: `iap_mailbox_ctrl`

## Requirements
- R1: The mailbox has six registers selected by `sfr_idx`: 0 status, 1 command, 2 address low, 3 address high, 4 data, 5 configuration. Address low, address high, data and the last command byte read back as written. Configuration reads back bit 6 (enable) and bits 1:0 (bank select); its other bits read 0. Indexes 6 and 7 read 0.
- R2: While configuration bit 6 is clear, a command write starts nothing and sets the error bit.
- R3: Only a write to the command register starts an operation. Code 0Eh requests a byte program and 0Dh requests a block erase. Any other code is rejected with the error bit set. Writes to the other registers start nothing.
- R4: With `ext_access` high and bank bits 00: code at or above `LOW_SPAN` that targets below it goes to block 1, and code at or above it that targets at or above it is rejected. Code below `LOW_SPAN` targets block 0 at any address.
- R5: With `ext_access` high and bank bits nonzero, the code always counts as block 0. A target below `LOW_SPAN` goes to block 1, and any other target is rejected.
- R6: With `ext_access` low and bank bits 00, a target below `LOW_SPAN` goes to block 1 and every other target goes to block 0. With nonzero bank bits, every target goes to block 0.
- R7: A request whose resolved block has its `lock_blk` bit set (bit 0 for block 0, bit 1 for block 1) is rejected with the error bit set.
- R8: An accepted program raises `flash_prog` for exactly `PROG_CYCLES` cycles. During that time `flash_blk` shows the resolved block (0 or 1), `flash_addr` shows {address high, address low} and `flash_wdata` shows the data byte. All of these are captured at the command write and hold steady while the mailbox changes.
- R9: An accepted block erase raises `flash_erase` for exactly `ERASE_CYCLES` cycles, which is longer than a program, and `flash_blk` shows the resolved block.
- R10: `osc_en` is high from the cycle after an accepted command write until the operation completes, and low at every other time.
- R11: Status bit 0 (`busy`) is set from the cycle after an accepted command write until completion. A command write while busy is ignored: it starts nothing and does not set the error bit.
- R12: Status bit 1 (error) is sticky and stays set until any write to the status register clears it. Status bit 2 (done) is set on completion and cleared when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_idx | input | 3 | Mailbox register index |
| sfr_wdata | input | DATA_W | Register write data |
| sfr_rdata | output | DATA_W | Register read data for `sfr_idx` |
| ext_access | input | 1 | High: code fetched from internal flash; low: code fetched externally |
| code_addr | input | ADDR_W | Address of the instruction issuing the command |
| lock_blk | input | 2 | Security lock per flash block |
| osc_en | output | 1 | Timing oscillator enable |
| flash_prog | output | 1 | Byte program enable to the array |
| flash_erase | output | 1 | Block erase enable to the array |
| flash_blk | output | 1 | Physical block being written |
| flash_addr | output | ADDR_W | Latched target address |
| flash_wdata | output | DATA_W | Latched program data |
| busy | output | 1 | Operation in progress |

## Verification
Two events can land on the same clock edge: the counter of a running operation reaching zero, and a fresh command write arriving. On that edge the sequencer still counts as busy. The bench issues a program and waits exactly `PROG_CYCLES-1` cycles. It then writes a command so that its strobe is sampled on the completion edge. The check that follows confirms that busy and the oscillator enable are low, that no second operation started, and that the status byte shows done without an error. Further bench tasks write the mailbox and issue a command in the middle of an operation, and confirm that the latched address and the active enable do not move.

// File: rtl/iap_pkg.sv
package iap_pkg;
   // Mailbox register indexes on the SFR bus
   typedef enum logic [2:0] {
      RI_STATUS  = 3'd0,
      RI_CMD     = 3'd1,
      RI_ADDR_LO = 3'd2,
      RI_ADDR_HI = 3'd3,
      RI_DATA    = 3'd4,
      RI_CFG     = 3'd5
   } reg_idx_e;

   localparam logic [7:0] CMD_PROG  = 8'h0E;
   localparam logic [7:0] CMD_ERASE = 8'h0D;
   localparam int         CFG_EN_BIT = 6;

   // Result of address resolution
   typedef enum logic [1:0] {
      TGT_B0   = 2'd0,
      TGT_B1   = 2'd1,
      TGT_NONE = 2'd2
   } tgt_e;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2
   } op_e;
endpackage

// File: rtl/iap_regfile.sv
module iap_regfile
   import iap_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit RDATA_REG = 1'b0,
   localparam int AW       = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              busy,
   input  logic              err_set,
   input  logic              done_set,
   input  logic              done_clr,
   output logic              cmd_wr,
   output logic [DATA_W-1:0] cmd_byte,
   output logic [AW-1:0]     addr,
   output logic [DATA_W-1:0] data,
   output logic              cfg_en,
   output logic [1:0]        bank,
   output logic              err_q,
   output logic              done_q
);
   logic [DATA_W-1:0] addr_lo_q, addr_hi_q, data_q, cmd_q;
   logic              en_q;
   logic [1:0]        bank_q;
   logic [DATA_W-1:0] rd_mux;

   assign cmd_wr   = wr && (idx == RI_CMD);
   assign cmd_byte = wdata;
   assign addr     = {addr_hi_q, addr_lo_q};
   assign data     = data_q;
   assign cfg_en   = en_q;
   assign bank     = bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_lo_q <= '0;
         addr_hi_q <= '0;
         data_q    <= '0;
         cmd_q     <= '0;
         en_q      <= 1'b0;
         bank_q    <= '0;
      end else if (wr) begin
         case (idx)
            RI_CMD:     cmd_q     <= wdata;
            RI_ADDR_LO: addr_lo_q <= wdata;
            RI_ADDR_HI: addr_hi_q <= wdata;
            RI_DATA:    data_q    <= wdata;
            RI_CFG: begin
               en_q   <= wdata[CFG_EN_BIT];
               bank_q <= wdata[1:0];
            end
            default: ;
         endcase
      end
   end

   // Sticky status flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (err_set)                           err_q <= 1'b1;
         else if (wr && (idx == RI_STATUS))     err_q <= 1'b0;
         if (done_clr)                          done_q <= 1'b0;
         else if (done_set)                     done_q <= 1'b1;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (idx)
         RI_STATUS: begin
            rd_mux[0] = busy;
            rd_mux[1] = err_q;
            rd_mux[2] = done_q;
         end
         RI_CMD:     rd_mux = cmd_q;
         RI_ADDR_LO: rd_mux = addr_lo_q;
         RI_ADDR_HI: rd_mux = addr_hi_q;
         RI_DATA:    rd_mux = data_q;
         RI_CFG: begin
            rd_mux[CFG_EN_BIT] = en_q;
            rd_mux[1:0]        = bank_q;
         end
         default: ;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/iap_resolve.sv
module iap_resolve
   import iap_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int LOW_SPAN = 'h2000
) (
   input  logic              ext_access,
   input  logic [1:0]        bank,
   input  logic [ADDR_W-1:0] code_addr,
   input  logic [ADDR_W-1:0] tgt_addr,
   output tgt_e              tgt
);
   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(LOW_SPAN);

   logic tgt_low, code_low, bank_zero;

   always_comb begin
      tgt_low   = tgt_addr < SPAN;
      code_low  = code_addr < SPAN;
      bank_zero = (bank == 2'b00);
      if (ext_access) begin
         // internal fetch: code in the low region runs from block 1 only when not banked
         if (bank_zero && code_low) tgt = TGT_B0;
         else                       tgt = tgt_low ? TGT_B1 : TGT_NONE;
      end else begin
         tgt = (bank_zero && tgt_low) ? TGT_B1 : TGT_B0;
      end
   end
endmodule

// File: rtl/iap_seq.sv
module iap_seq
   import iap_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 32,
   localparam int CNT_W       = $clog2(ERASE_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [DATA_W-1:0] cmd_byte,
   input  logic              cfg_en,
   input  tgt_e              tgt,
   input  logic [1:0]        lock,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              busy,
   output logic              osc_en,
   output logic              flash_prog,
   output logic              flash_erase,
   output logic              flash_blk,
   output logic [ADDR_W-1:0] flash_addr,
   output logic [DATA_W-1:0] flash_wdata,
   output logic              err_set,
   output logic              done_set,
   output logic              accept
);
   op_e               op_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              osc_q, blk_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              is_prog, is_erase, lock_hit, allowed, active;

   always_comb begin
      is_prog  = (cmd_byte == DATA_W'(CMD_PROG));
      is_erase = (cmd_byte == DATA_W'(CMD_ERASE));
      lock_hit = ((tgt == TGT_B0) && lock[0]) || ((tgt == TGT_B1) && lock[1]);
      allowed  = cfg_en && (is_prog || is_erase) && (tgt != TGT_NONE) && !lock_hit;
   end

   assign active   = (op_q != OP_IDLE);
   assign accept   = cmd_wr && !active && allowed;
   assign err_set  = cmd_wr && !active && !allowed;
   assign done_set = active && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         cnt_q  <= '0;
         blk_q  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         op_q   <= is_prog ? OP_PROG : OP_ERASE;
         cnt_q  <= is_prog ? CNT_W'(PROG_CYCLES - 1) : CNT_W'(ERASE_CYCLES - 1);
         blk_q  <= (tgt == TGT_B1);
         addr_q <= addr;
         data_q <= data;
      end else if (active) begin
         if (cnt_q == '0) op_q  <= OP_IDLE;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   // Oscillator enable kept in its own flop, switched by the same start/finish events
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        osc_q <= 1'b0;
      else if (accept)   osc_q <= 1'b1;
      else if (done_set) osc_q <= 1'b0;
   end

   assign busy        = active;
   assign osc_en      = osc_q;
   assign flash_prog  = (op_q == OP_PROG);
   assign flash_erase = (op_q == OP_ERASE);
   assign flash_blk   = blk_q;
   assign flash_addr  = addr_q;
   assign flash_wdata = data_q;
endmodule

// File: rtl/iap_mailbox_ctrl.sv
module iap_mailbox_ctrl
   import iap_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 2 * DATA_W,
   parameter int LOW_SPAN     = 'h2000,
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 32,
   parameter bit RDATA_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sfr_wr,
   input  logic [2:0]        sfr_idx,
   input  logic [DATA_W-1:0] sfr_wdata,
   output logic [DATA_W-1:0] sfr_rdata,
   input  logic              ext_access,
   input  logic [ADDR_W-1:0] code_addr,
   input  logic [1:0]        lock_blk,
   output logic              osc_en,
   output logic              flash_prog,
   output logic              flash_erase,
   output logic              flash_blk,
   output logic [ADDR_W-1:0] flash_addr,
   output logic [DATA_W-1:0] flash_wdata,
   output logic              busy
);
   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("iap_mailbox_ctrl: DATA_W must be at least 8");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_aw
         $error("iap_mailbox_ctrl: ADDR_W must be two data bytes");
      end
      if (PROG_CYCLES < 1) begin : g_bad_pc
         $error("iap_mailbox_ctrl: PROG_CYCLES must be positive");
      end
      if (ERASE_CYCLES <= PROG_CYCLES) begin : g_bad_ec
         $error("iap_mailbox_ctrl: ERASE_CYCLES must exceed PROG_CYCLES");
      end
      if (LOW_SPAN < 1 || LOW_SPAN >= (1 << ADDR_W)) begin : g_bad_span
         $error("iap_mailbox_ctrl: LOW_SPAN out of address range");
      end
   endgenerate

   logic              cmd_wr, cfg_en, err_q, done_q;
   logic              err_set, done_set, accept;
   logic [DATA_W-1:0] cmd_byte, mb_data;
   logic [ADDR_W-1:0] mb_addr;
   logic [1:0]        bank;
   tgt_e              tgt;

   iap_regfile #(.DATA_W(DATA_W), .RDATA_REG(RDATA_REG)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (sfr_wr),
      .idx      (sfr_idx),
      .wdata    (sfr_wdata),
      .rdata    (sfr_rdata),
      .busy     (busy),
      .err_set  (err_set),
      .done_set (done_set),
      .done_clr (accept),
      .cmd_wr   (cmd_wr),
      .cmd_byte (cmd_byte),
      .addr     (mb_addr),
      .data     (mb_data),
      .cfg_en   (cfg_en),
      .bank     (bank),
      .err_q    (err_q),
      .done_q   (done_q)
   );

   iap_resolve #(.ADDR_W(ADDR_W), .LOW_SPAN(LOW_SPAN)) res_i (
      .ext_access (ext_access),
      .bank       (bank),
      .code_addr  (code_addr),
      .tgt_addr   (mb_addr),
      .tgt        (tgt)
   );

   iap_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr      (cmd_wr),
      .cmd_byte    (cmd_byte),
      .cfg_en      (cfg_en),
      .tgt         (tgt),
      .lock        (lock_blk),
      .addr        (mb_addr),
      .data        (mb_data),
      .busy        (busy),
      .osc_en      (osc_en),
      .flash_prog  (flash_prog),
      .flash_erase (flash_erase),
      .flash_blk   (flash_blk),
      .flash_addr  (flash_addr),
      .flash_wdata (flash_wdata),
      .err_set     (err_set),
      .done_set    (done_set),
      .accept      (accept)
   );
endmodule

// File: rtl/iap_mailbox_chk.sv
module iap_mailbox_chk
   import iap_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 16,
   parameter int ERASE_CYCLES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sfr_wr,
   input logic [2:0]        sfr_idx,
   input logic              busy,
   input logic              osc_en,
   input logic              flash_prog,
   input logic              flash_erase,
   input logic              flash_blk,
   input logic [ADDR_W-1:0] flash_addr,
   input logic [DATA_W-1:0] flash_wdata,
   input logic              cfg_en,
   input logic              err_q
);
   logic [31:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   assert_en_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr && sfr_idx == RI_CMD && !busy && !cfg_en) |=> (!busy && err_q));

   assert_one_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flash_prog, flash_erase}));

   assert_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(flash_addr) && $stable(flash_wdata) && $stable(flash_blk)));

   assert_max_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < ERASE_CYCLES));

   assert_osc_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flash_prog || flash_erase) |-> osc_en);

   assert_osc_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !osc_en);

   assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sfr_wr && sfr_idx == RI_CMD) |=> !$rose(err_q));

   assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(sfr_wr && sfr_idx == RI_STATUS)) |=> err_q);
endmodule

bind iap_mailbox_ctrl iap_mailbox_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .sfr_wr      (sfr_wr),
   .sfr_idx     (sfr_idx),
   .busy        (busy),
   .osc_en      (osc_en),
   .flash_prog  (flash_prog),
   .flash_erase (flash_erase),
   .flash_blk   (flash_blk),
   .flash_addr  (flash_addr),
   .flash_wdata (flash_wdata),
   .cfg_en      (cfg_en),
   .err_q       (err_q)
);

// File: tb/iap_mailbox_ctrl_tb.sv
`timescale 1ns/1ps
module iap_mailbox_ctrl_tb_top;
   localparam int PC = 8;
   localparam int EC = 32;
   localparam logic [2:0] I_ST = 3'd0, I_CMD = 3'd1, I_LO = 3'd2, I_HI = 3'd3, I_DAT = 3'd4, I_CFG = 3'd5;
   localparam logic [7:0] C_PROG = 8'h0E, C_ERASE = 8'h0D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sfr_wr = 1'b0;
   logic [2:0]  sfr_idx = '0;
   logic [7:0]  sfr_wdata = '0;
   logic [7:0]  sfr_rdata;
   logic        ext_access = 1'b1;
   logic [15:0] code_addr = 16'h4000;
   logic [1:0]  lock_blk = 2'b00;
   logic        osc_en, flash_prog, flash_erase, flash_blk, busy;
   logic [15:0] flash_addr;
   logic [7:0]  flash_wdata;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   iap_mailbox_ctrl #(.PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut_i (
      .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_idx(sfr_idx),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_access(ext_access),
      .code_addr(code_addr), .lock_blk(lock_blk), .osc_en(osc_en),
      .flash_prog(flash_prog), .flash_erase(flash_erase), .flash_blk(flash_blk),
      .flash_addr(flash_addr), .flash_wdata(flash_wdata), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] idx, input logic [7:0] v);
      sfr_wr = 1'b1; sfr_idx = idx; sfr_wdata = v;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] idx, output logic [7:0] v);
      sfr_idx = idx;
      #1;
      v = sfr_rdata;
   endtask

   // Load mailbox, issue a command, check accept/reject and the whole operation
   task automatic do_op(input string req, input logic [7:0] cmd, input logic [15:0] ta,
                        input logic [7:0] d, input bit ok, input bit blk);
      logic [7:0] st;
      int len;
      wr_reg(I_ST, 8'h00);
      wr_reg(I_LO, ta[7:0]);
      wr_reg(I_HI, ta[15:8]);
      wr_reg(I_DAT, d);
      wr_reg(I_CMD, cmd);
      if (ok) begin
         chk(busy == 1'b1, {req, " start busy"}, 32'(busy), 1);
         chk(flash_prog == (cmd == C_PROG) && flash_erase == (cmd == C_ERASE), {req, " enable"},
             {30'b0, flash_erase, flash_prog}, {30'b0, cmd == C_ERASE, cmd == C_PROG});
         chk(flash_blk == blk, {req, " block"}, 32'(flash_blk), 32'(blk));
         if (cmd == C_PROG)
            chk(flash_addr == ta && flash_wdata == d, {req, " R8 addr/data"},
                {8'h0, flash_wdata, flash_addr}, {8'h0, d, ta});
         len = 0;
         while (busy) begin
            if (!osc_en) chk(1'b0, "R10 osc during op", 0, 1);
            len++;
            @(negedge clk);
         end
         chk(len == ((cmd == C_PROG) ? PC : EC), (cmd == C_PROG) ? "R8 length" : "R9 length",
             32'(len), (cmd == C_PROG) ? PC : EC);
         chk(osc_en == 1'b0, "R10 osc off after op", 32'(osc_en), 0);
         rd_reg(I_ST, st);
         chk(st == 8'h04, {req, " R12 status done"}, 32'(st), 32'h04);
      end else begin
         chk(!busy && !osc_en && !flash_prog && !flash_erase, {req, " no start"},
             {28'b0, busy, osc_en, flash_prog, flash_erase}, 0);
         rd_reg(I_ST, st);
         chk(st[1] == 1'b1, {req, " error bit"}, 32'(st), 32'h02);
         @(negedge clk);
         chk(!busy, {req, " stays idle"}, 32'(busy), 0);
      end
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk(!busy && !osc_en && !flash_prog && !flash_erase, "R10 reset idle",
          {28'b0, busy, osc_en, flash_prog, flash_erase}, 0);
      for (int i = 0; i < 8; i++) begin
         rd_reg(3'(i), v);
         chk(v == 8'h00, "R1 reset value", 32'(v), 0);
      end
   endtask

   task automatic t_regs();
      logic [7:0] v;
      wr_reg(I_LO, 8'h34); wr_reg(I_HI, 8'h12); wr_reg(I_DAT, 8'hA5); wr_reg(I_CFG, 8'hFF);
      rd_reg(I_LO, v);  chk(v == 8'h34, "R1 addr low", 32'(v), 32'h34);
      rd_reg(I_HI, v);  chk(v == 8'h12, "R1 addr high", 32'(v), 32'h12);
      rd_reg(I_DAT, v); chk(v == 8'hA5, "R1 data", 32'(v), 32'hA5);
      rd_reg(I_CFG, v); chk(v == 8'h43, "R1 config", 32'(v), 32'h43);
      rd_reg(3'd6, v);  chk(v == 8'h00, "R1 unused index", 32'(v), 0);
      chk(!busy, "R3 no start from mailbox writes", 32'(busy), 0);
      wr_reg(I_CFG, 8'h00);
   endtask

   task automatic t_enable();
      ext_access = 1'b1; code_addr = 16'h4000; lock_blk = 2'b00;
      wr_reg(I_CFG, 8'h00);
      do_op("R2 disabled", C_PROG, 16'h1000, 8'h11, 1'b0, 1'b0);
   endtask

   task automatic t_codes();
      logic [7:0] v;
      wr_reg(I_CFG, 8'h40);
      do_op("R3 bad code", 8'h55, 16'h1000, 8'h22, 1'b0, 1'b0);
      rd_reg(I_CMD, v); chk(v == 8'h55, "R1 command readback", 32'(v), 32'h55);
      wr_reg(I_ST, 8'h00);
      wr_reg(I_DAT, C_PROG);
      chk(!busy, "R3 data write does not start", 32'(busy), 0);
   endtask

   task automatic t_ea_hi_bank0();
      ext_access = 1'b1; wr_reg(I_CFG, 8'h40);
      code_addr = 16'h4000;
      do_op("R4 blk0 code low target", C_PROG, 16'h1000, 8'h3C, 1'b1, 1'b1);
      do_op("R4 blk0 code high target", C_PROG, 16'h3000, 8'h3C, 1'b0, 1'b0);
      do_op("R4 boundary 2000", C_PROG, 16'h2000, 8'h3C, 1'b0, 1'b0);
      code_addr = 16'h0100;
      do_op("R4 blk1 code high target", C_PROG, 16'h5000, 8'hC3, 1'b1, 1'b0);
      do_op("R4 blk1 code low target", C_PROG, 16'h0100, 8'h99, 1'b1, 1'b0);
   endtask

   task automatic t_ea_hi_bankn();
      ext_access = 1'b1; wr_reg(I_CFG, 8'h42);
      code_addr = 16'h0100;
      do_op("R5 low target", C_PROG, 16'h0100, 8'h77, 1'b1, 1'b1);
      do_op("R5 high target", C_PROG, 16'h8000, 8'h77, 1'b0, 1'b0);
   endtask

   task automatic t_ea_lo();
      ext_access = 1'b0; code_addr = 16'h0000; wr_reg(I_CFG, 8'h40);
      do_op("R6 bank0 low", C_PROG, 16'h1FFF, 8'h01, 1'b1, 1'b1);
      do_op("R6 bank0 high", C_PROG, 16'h2000, 8'h02, 1'b1, 1'b0);
      wr_reg(I_CFG, 8'h41);
      do_op("R6 bank1 low", C_PROG, 16'h0000, 8'h03, 1'b1, 1'b0);
      ext_access = 1'b1;
   endtask

   task automatic t_lock();
      ext_access = 1'b1; code_addr = 16'h4000; wr_reg(I_CFG, 8'h40);
      lock_blk = 2'b10;
      do_op("R7 locked block1", C_PROG, 16'h1000, 8'h44, 1'b0, 1'b0);
      lock_blk = 2'b01;
      do_op("R7 other lock", C_PROG, 16'h1000, 8'h44, 1'b1, 1'b1);
      lock_blk = 2'b00;
   endtask

   task automatic t_erase();
      ext_access = 1'b0; code_addr = 16'h0000; wr_reg(I_CFG, 8'h40);
      do_op("R9 erase block0", C_ERASE, 16'h9000, 8'h00, 1'b1, 1'b0);
      do_op("R9 erase block1", C_ERASE, 16'h0010, 8'h00, 1'b1, 1'b1);
      ext_access = 1'b1;
   endtask

   task automatic t_overlap();
      logic [7:0] st;
      ext_access = 1'b1; code_addr = 16'h4000; wr_reg(I_CFG, 8'h40);
      wr_reg(I_ST, 8'h00);
      wr_reg(I_LO, 8'h00); wr_reg(I_HI, 8'h10); wr_reg(I_DAT, 8'h5A);
      wr_reg(I_CMD, C_PROG);
      wr_reg(I_LO, 8'hFF);
      chk(flash_addr == 16'h1000, "R8 address latched", 32'(flash_addr), 32'h1000);
      wr_reg(I_CMD, C_ERASE);
      chk(flash_prog && !flash_erase, "R11 busy command ignored", {30'b0, flash_erase, flash_prog}, 1);
      rd_reg(I_ST, st);
      chk(st == 8'h01, "R11 no error while busy", 32'(st), 1);
      repeat (PC - 3) @(negedge clk);
      wr_reg(I_CMD, C_PROG);           // strobe sampled on the completion edge
      chk(!busy && !osc_en && !flash_prog, "R11 completion-edge write ignored",
          {29'b0, busy, osc_en, flash_prog}, 0);
      rd_reg(I_ST, st);
      chk(st == 8'h04, "R11 R12 status after coincident write", 32'(st), 4);
      @(negedge clk);
      chk(!busy, "R11 stays idle", 32'(busy), 0);
   endtask

   task automatic t_sticky();
      logic [7:0] st;
      ext_access = 1'b1; code_addr = 16'h4000;
      wr_reg(I_ST, 8'h00);
      wr_reg(I_CFG, 8'h00);
      wr_reg(I_LO, 8'h00); wr_reg(I_HI, 8'h10);
      wr_reg(I_CMD, C_PROG);
      wr_reg(I_CFG, 8'h40);
      wr_reg(I_CMD, C_PROG);
      rd_reg(I_ST, st);
      chk(st == 8'h03, "R12 error kept, done cleared on accept", 32'(st), 3);
      while (busy) @(negedge clk);
      rd_reg(I_ST, st);
      chk(st == 8'h06, "R12 error and done", 32'(st), 6);
      wr_reg(I_ST, 8'h00);
      rd_reg(I_ST, st);
      chk(st == 8'h04, "R12 status write clears error", 32'(st), 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_regs();
      t_enable();
      t_codes();
      t_ea_hi_bank0();
      t_ea_hi_bankn();
      t_ea_lo();
      t_lock();
      t_erase();
      t_overlap();
      t_sticky();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule